// File: doc/BRIEF.md
# Interrupt Level Request Arbiter

This block sits between fifteen level-sensitive external interrupt request lines and a processor core's trap-entry logic. It holds one pending trap-type register. Whenever that register is empty or already holds an external-interrupt trap, the block looks at the request lines, picks the highest active level and stores the matching external-interrupt trap type (group code 0x10 combined with the level). Each time the stored type changes to a new external-interrupt code, a one-cycle hard-interrupt request pulse goes to the core. When every line falls while an external-interrupt trap is pending, the register is cleared and a one-cycle withdraw pulse is issued.

Other trap sources can place a non-interrupt trap type in the same register through a load strobe. The arbiter then leaves the register alone until the trap-entry logic consumes it. When the core takes a trap it pulses the taken strobe. The register returns to zero, and if the consumed trap was an external interrupt the block acknowledges it to the interrupt source with the trap number. All results are registered and appear one clock after the inputs that caused them.

Top module: `lvl_irq_arbiter`

## Requirements
- R1: A synchronous active-high reset makes the pending index 0 and holds irqRaise, irqDrop and ackValid low one cycle later, even while request lines are active.
- R2: Among request bits 15 down to 1 the highest set bit wins, and the stored trap type is 0x10 OR the winning bit number (0x11 to 0x1F). Bit 0 is ignored.
- R3: irqRaise is high for exactly one cycle, in the cycle after the pending index is set to an external-interrupt type different from its previous value. Selecting the same type again gives no pulse.
- R4: When bits 15..1 are all low and the pending index is in the external-interrupt group, the index becomes 0 on the next cycle, irqDrop pulses for one cycle and irqActive goes low.
- R5: A nonzero pending index outside the external-interrupt group is not changed by the request lines.
- R6: A trapTaken pulse clears the pending index on the next cycle. If the index was in the external-interrupt group, ackValid pulses in that cycle with ackTrap equal to the consumed index. Otherwise ackValid stays low.
- R7: After a held-off non-interrupt trap has been taken, active request lines are arbitrated again on the following cycle, with a raise pulse.
- R8: A trapLoad pulse writes trapLoadType into the pending index on the next cycle. It takes precedence over both arbitration and withdrawal in that cycle.
- R9: With bits 15..1 all low, a pending index that is 0 or outside the external-interrupt group stays unchanged, and irqDrop stays low.
- R10: pendValid is high exactly when the pending index is nonzero. irqActive is high exactly when the index's upper four bits equal 0x1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqLines | input | 16 | Level requests; bits 15..1 used, bit 15 highest |
| trapLoad | input | 1 | Pulse: load a non-interrupt trap type |
| trapLoadType | input | 8 | Trap type written by trapLoad |
| trapTaken | input | 1 | Pulse: core has entered the pending trap |
| pendIdx | output | 8 | Pending trap type, 0 when empty |
| pendValid | output | 1 | Pending index is nonzero |
| irqActive | output | 1 | Pending index is an external interrupt |
| irqRaise | output | 1 | One-cycle hard-interrupt request to the core |
| irqDrop | output | 1 | One-cycle withdrawal of the request |
| ackValid | output | 1 | One-cycle acknowledge to the interrupt source |
| ackTrap | output | 8 | Trap number carried by the acknowledge |

## Verification
The assertions rely on three properties of the surrounding logic. trapTaken and trapLoad are never high in the same cycle. trapTaken only arrives while a trap is pending. A loaded trap type is nonzero and lies outside the external-interrupt group. The stimulus table and the directed tests follow all three rules. Loads use types 0x05 and 0x2B, and every taken pulse is issued only after the table shows a nonzero index. Within these limits the bench tests priority, same-type reselection, withdrawal, hold-off of a foreign trap and load precedence.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int DEF_NUM_LVL = 16;
  localparam int DEF_TT_W    = 8;
  localparam logic [DEF_TT_W-1:0] DEF_EXT_BASE = 8'h10;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic selLoad;   // store arbitration result
    logic extLoad;   // store externally supplied trap type
    logic idxClear;  // empty the pending register
    logic raise;     // request pulse toward core
    logic drop;      // withdraw pulse toward core
    logic ack;       // acknowledge pulse toward source
  } ctlStrobes_t;

endpackage

// File: rtl/lvl_irq_datapath.sv
module lvl_irq_datapath
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int TT_W = DEF_TT_W,
  parameter logic [TT_W-1:0] EXT_BASE = DEF_EXT_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] reqLines,
  input  logic [TT_W-1:0]    loadType,
  input  ctlStrobes_t        ctl,
  output logic               anyReq,
  output logic [TT_W-1:0]    selType,
  output logic [TT_W-1:0]    pendIdx,
  output logic               irqRaise,
  output logic               irqDrop,
  output logic               ackValid,
  output logic [TT_W-1:0]    ackTrap
);

  localparam int LVL_W = $clog2(NUM_LVL);
  localparam int GRP_W = TT_W - LVL_W;

  logic [NUM_LVL-1:1] higherAny;
  logic [NUM_LVL-1:1] grant;
  logic [LVL_W-1:0]   selLvl;
  logic               unusedLvl0;

  assign unusedLvl0 = reqLines[0];

  // priority chain: a level wins when nothing above it is requesting
  assign higherAny[NUM_LVL-1] = 1'b0;
  genvar g;
  generate
    for (g = NUM_LVL - 2; g >= 1; g--) begin : g_chain
      assign higherAny[g] = higherAny[g+1] | reqLines[g+1];
    end
    for (g = 1; g < NUM_LVL; g++) begin : g_grant
      assign grant[g] = reqLines[g] & ~higherAny[g];
    end
  endgenerate

  always_comb begin
    selLvl = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (grant[i]) selLvl = LVL_W'(i);
    end
  end

  assign anyReq  = |reqLines[NUM_LVL-1:1];
  assign selType = EXT_BASE | {{GRP_W{1'b0}}, selLvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      pendIdx  <= '0;
      irqRaise <= 1'b0;
      irqDrop  <= 1'b0;
      ackValid <= 1'b0;
      ackTrap  <= '0;
    end else begin
      irqRaise <= ctl.raise;
      irqDrop  <= ctl.drop;
      ackValid <= ctl.ack;
      if (ctl.ack) ackTrap <= pendIdx;
      if (ctl.idxClear)     pendIdx <= '0;
      else if (ctl.extLoad) pendIdx <= loadType;
      else if (ctl.selLoad) pendIdx <= selType;
    end
  end

  // R3
  raise_changed_chk: assert property (@(posedge clk) disable iff (rst)
    irqRaise |-> (pendIdx != $past(pendIdx)) &&
                 (pendIdx[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W]));

  // R4
  drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    irqDrop |-> (pendIdx == '0) &&
                ($past(pendIdx[TT_W-1:LVL_W]) == EXT_BASE[TT_W-1:LVL_W]));

  // R6
  ack_ext_only_chk: assert property (@(posedge clk) disable iff (rst)
    ackValid |-> (pendIdx == '0) &&
                 (ackTrap[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W]));

endmodule

// File: rtl/lvl_irq_control.sv
module lvl_irq_control
  import lvl_irq_pkg::*;
#(
  parameter int TT_W = DEF_TT_W,
  parameter int LVL_W = 4,
  parameter logic [TT_W-1:0] EXT_BASE = DEF_EXT_BASE
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trapTaken,
  input  logic            trapLoad,
  input  logic            anyReq,
  input  logic [TT_W-1:0] selType,
  input  logic [TT_W-1:0] pendIdx,
  output ctlStrobes_t     ctl
);

  logic pendExt;
  logic pendZero;

  assign pendExt  = pendIdx[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W];
  assign pendZero = pendIdx == '0;

  // order: taken, then load, then arbitration, then withdrawal
  always_comb begin
    ctl = '0;
    if (trapTaken) begin
      ctl.idxClear = 1'b1;
      ctl.ack      = pendExt;
    end else if (trapLoad) begin
      ctl.extLoad = 1'b1;
    end else if (anyReq && (pendZero || pendExt)) begin
      ctl.selLoad = 1'b1;
      ctl.raise   = selType != pendIdx;
    end else if (!anyReq && pendExt) begin
      ctl.idxClear = 1'b1;
      ctl.drop     = 1'b1;
    end
  end

  // R5
  foreign_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pendZero && !pendExt && !trapTaken && !trapLoad) |=> $stable(pendIdx));

  // R9
  idle_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!anyReq && !pendExt && !trapTaken && !trapLoad) |=> $stable(pendIdx));

endmodule

// File: rtl/lvl_irq_arbiter.sv
module lvl_irq_arbiter
  import lvl_irq_pkg::*;
#(
  parameter int NUM_LVL = DEF_NUM_LVL,
  parameter int TT_W = DEF_TT_W,
  parameter logic [TT_W-1:0] EXT_BASE = DEF_EXT_BASE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] reqLines,
  input  logic               trapLoad,
  input  logic [TT_W-1:0]    trapLoadType,
  input  logic               trapTaken,
  output logic [TT_W-1:0]    pendIdx,
  output logic               pendValid,
  output logic               irqActive,
  output logic               irqRaise,
  output logic               irqDrop,
  output logic               ackValid,
  output logic [TT_W-1:0]    ackTrap
);

  localparam int LVL_W = $clog2(NUM_LVL);

  ctlStrobes_t         ctl;
  logic                anyReq;
  logic [TT_W-1:0]     selType;

  lvl_irq_control #(.TT_W(TT_W), .LVL_W(LVL_W), .EXT_BASE(EXT_BASE)) u_ctl (
    .clk(clk), .rst(rst), .trapTaken(trapTaken), .trapLoad(trapLoad),
    .anyReq(anyReq), .selType(selType), .pendIdx(pendIdx), .ctl(ctl)
  );

  lvl_irq_datapath #(.NUM_LVL(NUM_LVL), .TT_W(TT_W), .EXT_BASE(EXT_BASE)) u_dp (
    .clk(clk), .rst(rst), .reqLines(reqLines), .loadType(trapLoadType),
    .ctl(ctl), .anyReq(anyReq), .selType(selType), .pendIdx(pendIdx),
    .irqRaise(irqRaise), .irqDrop(irqDrop), .ackValid(ackValid),
    .ackTrap(ackTrap)
  );

  assign pendValid = pendIdx != '0;
  assign irqActive = pendIdx[TT_W-1:LVL_W] == EXT_BASE[TT_W-1:LVL_W];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pendIdx == '0) && !irqRaise && !irqDrop && !ackValid);

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (trapLoad && !trapTaken) |=> pendIdx == $past(trapLoadType));

  // R6 input rule: taken and load never coincide, taken only when pending
  taken_excl_chk: assert property (@(posedge clk) disable iff (rst)
    trapTaken |-> !trapLoad && pendValid);

endmodule

// File: tb/lvl_irq_arbiter_test.sv
`timescale 1ns/1ps
module lvl_irq_arbiter_test;

  typedef struct packed {
    logic        taken;
    logic        load;
    logic [7:0]  ltype;
    logic [15:0] req;
    logic [7:0]  eIdx;
    logic        eRaise;
    logic        eDrop;
    logic        eAck;
    logic [7:0]  eAckTrap;
  } row_t;

  localparam int NROWS = 21;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0,1'b0,8'h00,16'h0001,8'h00,1'b0,1'b0,1'b0,8'h00}, // R2 bit0 ignored
    '{1'b0,1'b0,8'h00,16'h0008,8'h13,1'b1,1'b0,1'b0,8'h00}, // R2
    '{1'b0,1'b0,8'h00,16'h0008,8'h13,1'b0,1'b0,1'b0,8'h00}, // R3 same type
    '{1'b0,1'b0,8'h00,16'h0108,8'h18,1'b1,1'b0,1'b0,8'h00}, // R2
    '{1'b0,1'b0,8'h00,16'h8108,8'h1F,1'b1,1'b0,1'b0,8'h00}, // R2 top level
    '{1'b0,1'b0,8'h00,16'h0100,8'h18,1'b1,1'b0,1'b0,8'h00}, // R3 lower
    '{1'b0,1'b0,8'h00,16'h0000,8'h00,1'b0,1'b1,1'b0,8'h00}, // R4
    '{1'b0,1'b0,8'h00,16'h0000,8'h00,1'b0,1'b0,1'b0,8'h00}, // R9
    '{1'b0,1'b0,8'h00,16'h0004,8'h12,1'b1,1'b0,1'b0,8'h00}, // R2
    '{1'b1,1'b0,8'h00,16'h0004,8'h00,1'b0,1'b0,1'b1,8'h12}, // R6 ack
    '{1'b0,1'b0,8'h00,16'h0004,8'h12,1'b1,1'b0,1'b0,8'h00}, // R3 again
    '{1'b0,1'b1,8'h05,16'h0004,8'h05,1'b0,1'b0,1'b0,8'h00}, // R8
    '{1'b0,1'b0,8'h00,16'h8000,8'h05,1'b0,1'b0,1'b0,8'h00}, // R5
    '{1'b0,1'b0,8'h00,16'h0000,8'h05,1'b0,1'b0,1'b0,8'h00}, // R9
    '{1'b0,1'b0,8'h00,16'h0400,8'h05,1'b0,1'b0,1'b0,8'h00}, // R5
    '{1'b1,1'b0,8'h00,16'h0400,8'h00,1'b0,1'b0,1'b0,8'h00}, // R6 no ack
    '{1'b0,1'b0,8'h00,16'h0400,8'h1A,1'b1,1'b0,1'b0,8'h00}, // R7
    '{1'b0,1'b1,8'h2B,16'h0000,8'h2B,1'b0,1'b0,1'b0,8'h00}, // R8 over drop
    '{1'b1,1'b0,8'h00,16'h0000,8'h00,1'b0,1'b0,1'b0,8'h00}, // R6 no ack
    '{1'b0,1'b0,8'h00,16'hFFFE,8'h1F,1'b1,1'b0,1'b0,8'h00}, // R2 all
    '{1'b0,1'b0,8'h00,16'hFFFF,8'h1F,1'b0,1'b0,1'b0,8'h00}  // R3 steady
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] reqLines = '0;
  logic        trapLoad = 1'b0;
  logic [7:0]  trapLoadType = '0;
  logic        trapTaken = 1'b0;
  logic [7:0]  pendIdx;
  logic        pendValid;
  logic        irqActive;
  logic        irqRaise;
  logic        irqDrop;
  logic        ackValid;
  logic [7:0]  ackTrap;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  lvl_irq_arbiter uut (
    .clk(clk), .rst(rst), .reqLines(reqLines), .trapLoad(trapLoad),
    .trapLoadType(trapLoadType), .trapTaken(trapTaken), .pendIdx(pendIdx),
    .pendValid(pendValid), .irqActive(irqActive), .irqRaise(irqRaise),
    .irqDrop(irqDrop), .ackValid(ackValid), .ackTrap(ackTrap)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string where, input logic [7:0] eIdx,
                          input logic eRaise, input logic eDrop,
                          input logic eAck, input logic [7:0] eTrap);
    check({where, " R2 R5 R8 pendIdx"}, 32'(pendIdx), 32'(eIdx));
    check({where, " R3 irqRaise"}, 32'(irqRaise), 32'(eRaise));
    check({where, " R4 R9 irqDrop"}, 32'(irqDrop), 32'(eDrop));
    check({where, " R6 ackValid"}, 32'(ackValid), 32'(eAck));
    if (eAck) check({where, " R6 ackTrap"}, 32'(ackTrap), 32'(eTrap));
    check({where, " R10 pendValid"}, 32'(pendValid), 32'(eIdx != 8'h00));
    check({where, " R10 irqActive"}, 32'(irqActive), 32'(eIdx[7:4] == 4'h1));
  endtask

  task automatic applyStep(input logic tk, input logic ld,
                           input logic [7:0] lt, input logic [15:0] rq);
    @(negedge clk);
    trapTaken = tk;
    trapLoad = ld;
    trapLoadType = lt;
    reqLines = rq;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1 reset", 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 0; r < NROWS; r++) begin
      applyStep(ROWS[r].taken, ROWS[r].load, ROWS[r].ltype, ROWS[r].req);
      checkAll($sformatf("row%0d", r), ROWS[r].eIdx, ROWS[r].eRaise,
               ROWS[r].eDrop, ROWS[r].eAck, ROWS[r].eAckTrap);
    end

    // R1: reset while lines are active
    @(negedge clk);
    rst = 1'b1;
    reqLines = 16'h4000;
    @(posedge clk);
    #1;
    checkAll("R1 midrun", 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R3: first selection after reset raises, level 14 -> 0x1E
    checkAll("R3 postreset", 8'h1E, 1'b1, 1'b0, 1'b0, 8'h00);
    applyStep(1'b0, 1'b0, 8'h00, 16'h0002);
    checkAll("R2 lowest", 8'h11, 1'b1, 1'b0, 1'b0, 8'h00);
    applyStep(1'b1, 1'b0, 8'h00, 16'h0000);
    checkAll("R6 ack lvl1", 8'h00, 1'b0, 1'b0, 1'b1, 8'h11);
    applyStep(1'b0, 1'b0, 8'h00, 16'h0000);
    checkAll("R9 idle", 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule